// File: doc/BRIEF.md
# Divider and Programmable Timer Unit

This block keeps time for a small processor subsystem. A tick input arrives once per machine cycle, and each tick adds four to an internal base-cycle count. Two counters are derived from that count. The first is an 8-bit divider that advances at a fixed rate. The second is a programmable 8-bit counter whose step interval is chosen from four base-cycle thresholds.

When the programmable counter steps past 255, it does not wrap to zero. It loads a software-held modulo value instead, and the block raises a single-cycle interrupt request. A host reaches the four registers through a simple write port and a combinational read port: divider, counter, modulo and control.

Top module: `timer_unit`

## Requirements
- R1: Each cycle with tick_i high adds 4 to the 16-bit base count. The divider register (address 0) reads bits 15:8 of that count, so it advances once per 64 ticks. Without a tick the count holds.
- R2: A write of any data to address 0 clears the whole base count to zero in that cycle, and a tick in the same cycle is dropped. This restarts both the divider and the counter's step phase.
- R3: Control bits 1:0 select the step threshold: 0 gives 1024 base cycles, 1 gives 16, 2 gives 64 and 3 gives 256. The counter steps on a tick whose updated base count is a multiple of the selected threshold.
- R4: Control bit 2 enables the counter. While it is clear, the counter holds its value and irq_o stays low.
- R5: A step taken while the counter holds 255 loads the modulo register (address 2) as it stood before that edge.
- R6: Every overflow drives irq_o high for exactly the one cycle after the overflow edge, giving one pulse per overflow.
- R7: A write to the counter (address 1) takes priority over a step in the same cycle and suppresses any overflow in that cycle.
- R8: Register map: 0 is the divider, 1 the counter, 2 the modulo value and 3 the control register. Control keeps bits 2:0 and reads zeros above them. rd_data_o returns the register at rd_addr_i combinationally.
- R9: After reset every register reads zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Machine-cycle step (4 base cycles) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write register address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read register address |
| rd_data_o | output | 8 | Read data for rd_addr_i |
| irq_o | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The bench runs a counter at 254 into overflow with a nonzero modulo value. A design that wraps to zero, or that reloads one step late, shows the wrong count, and a level-held request shows up as extra pulses against the model's overflow total. A counter write is placed on the same edge as a pending step at 255; a design that lets the step win shows a reload and a spurious pulse. Each threshold is probed one tick before and one tick after its boundary, which exposes a wrong threshold table or an off-by-one step. Random runs also land modulo and control writes on overflow edges, where a reload that uses the freshly written modulo value, or a divider clear that leaves the step phase running, diverges from the model.

// File: rtl/timer_unit_pkg.sv
package timer_unit_pkg;

  typedef enum logic [1:0] {
    REG_DIV = 2'd0,
    REG_CNT = 2'd1,
    REG_MOD = 2'd2,
    REG_CTL = 2'd3
  } reg_addr_e;

  localparam int unsigned CTL_W      = 3;
  localparam int unsigned CTL_EN_BIT = 2;
  localparam int unsigned N_RATES    = 4;

  // log2 of the base-cycle threshold per select code
  function automatic int unsigned rate_log2(input int unsigned sel);
    case (sel)
      0:       return 10;
      1:       return 4;
      2:       return 6;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/timer_base_cnt.sv
module timer_base_cnt #(
  parameter int unsigned BASE_W   = 16,
  parameter int unsigned STEP_LOG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  output logic [BASE_W-1:0] base_o,
  output logic [BASE_W-1:0] base_nxt_o,
  output logic              adv_o
);
  localparam logic [BASE_W-1:0] STEP = BASE_W'(1) << STEP_LOG;

  logic [BASE_W-1:0] base_q;

  assign base_nxt_o = base_q + STEP;
  assign adv_o      = tick_i & ~clr_i;
  assign base_o     = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_q <= '0;
    else if (clr_i)  base_q <= '0;
    else if (tick_i) base_q <= base_nxt_o;
  end
endmodule

// File: rtl/timer_rate_sel.sv
module timer_rate_sel
  import timer_unit_pkg::*;
#(
  parameter int unsigned BASE_W = 16
) (
  input  logic [BASE_W-1:0] base_nxt_i,
  input  logic              adv_i,
  input  logic              en_i,
  input  logic [1:0]        sel_i,
  output logic              strobe_o
);
  logic [N_RATES-1:0] hit;

  for (genvar g = 0; g < N_RATES; g++) begin : g_rate
    localparam int unsigned LG = rate_log2(g);
    assign hit[g] = (base_nxt_i[LG-1:0] == '0);
  end

  assign strobe_o = adv_i & en_i & hit[sel_i];
endmodule

// File: rtl/timer_count.sv
module timer_count #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] mod_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_i) begin
        cnt_q <= wr_data_i;
      end else if (strobe_i) begin
        if (cnt_q == '1) begin
          cnt_q <= mod_i;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/timer_unit.sv
module timer_unit
  import timer_unit_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BASE_W   = 16,
  parameter int unsigned STEP_LOG = 2,
  parameter int unsigned DIV_LSB  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned DIV_MSB = DIV_LSB + DATA_W - 1;

  logic [BASE_W-1:0] base_q, base_nxt;
  logic [DATA_W-1:0] cnt_q, mod_q;
  logic [CTL_W-1:0]  ctrl_q;
  logic              adv, strobe, div_wr, cnt_wr;

  assign div_wr = wr_en_i & (reg_addr_e'(wr_addr_i) == REG_DIV);
  assign cnt_wr = wr_en_i & (reg_addr_e'(wr_addr_i) == REG_CNT);

  timer_base_cnt #(.BASE_W(BASE_W), .STEP_LOG(STEP_LOG)) u_base (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .clr_i     (div_wr),
    .base_o    (base_q),
    .base_nxt_o(base_nxt),
    .adv_o     (adv)
  );

  timer_rate_sel #(.BASE_W(BASE_W)) u_rate (
    .base_nxt_i(base_nxt),
    .adv_i     (adv),
    .en_i      (ctrl_q[CTL_EN_BIT]),
    .sel_i     (ctrl_q[1:0]),
    .strobe_o  (strobe)
  );

  timer_count #(.DATA_W(DATA_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .wr_i     (cnt_wr),
    .wr_data_i(wr_data_i),
    .mod_i    (mod_q),
    .cnt_o    (cnt_q),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      if (reg_addr_e'(wr_addr_i) == REG_MOD) mod_q  <= wr_data_i;
      if (reg_addr_e'(wr_addr_i) == REG_CTL) ctrl_q <= wr_data_i[CTL_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr_e'(rd_addr_i))
      REG_DIV: rd_data_o = base_q[DIV_MSB:DIV_LSB];
      REG_CNT: rd_data_o = cnt_q;
      REG_MOD: rd_data_o = mod_q;
      default: rd_data_o = {{(DATA_W-CTL_W){1'b0}}, ctrl_q};
    endcase
  end
endmodule

// File: rtl/timer_unit_chk.sv
module timer_unit_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BASE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              irq_o,
  input logic [BASE_W-1:0] base_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] mod_q,
  input logic [2:0]        ctrl_q
);
  logic div_wr, cnt_wr;
  assign div_wr = wr_en_i && wr_addr_i == 2'd0;
  assign cnt_wr = wr_en_i && wr_addr_i == 2'd1;

  assert_tick_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !div_wr) |=> base_q == $past(base_q) + BASE_W'(4));

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !div_wr) |=> $stable(base_q));

  assert_div_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_wr |=> base_q == '0);

  assert_hold_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[2] && !cnt_wr) |=> ($stable(cnt_q) && !irq_o));

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt_q == $past(mod_q));

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_write_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cnt_q == $past(wr_data_i) && !irq_o));
endmodule

bind timer_unit timer_unit_chk #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .irq_o    (irq_o),
  .base_q   (base_q),
  .cnt_q    (cnt_q),
  .mod_q    (mod_q),
  .ctrl_q   (ctrl_q)
);

// File: tb/timer_unit_bench.sv
module timer_unit_bench;
  localparam time CLK_P = 8ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int checks = 0, failures = 0;
  int n_ovf = 0, n_pulse = 0;
  bit done = 0;

  int unsigned m_base = 0;
  int unsigned m_cnt = 0, m_mod = 0, m_ctl = 0;
  bit m_irq = 0;

  timer_unit u_timer_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic int unsigned thr_of(input int unsigned sel);
    case (sel)
      0: return 1024;
      1: return 16;
      2: return 64;
      default: return 256;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input bit we, input bit [1:0] wa, input bit [7:0] wd);
    bit dw, stb;
    int unsigned old_ctl, old_mod;
    tick_i = tk; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    dw = we && wa == 2'd0;
    old_ctl = m_ctl; old_mod = m_mod;
    if (dw) m_base = 0;
    else if (tk) m_base = (m_base + 4) & 32'hFFFF;
    stb = tk && !dw && old_ctl[2] && (m_base % thr_of(old_ctl & 3)) == 0;
    m_irq = 0;
    if (we && wa == 2'd1) m_cnt = wd;
    else if (stb) begin
      if (m_cnt == 255) begin m_cnt = old_mod; m_irq = 1; n_ovf++; end
      else m_cnt++;
    end
    if (we && wa == 2'd2) m_mod = wd;
    if (we && wa == 2'd3) m_ctl = wd & 7;
    @(posedge clk_i); #1;
    tick_i = 0; wr_en_i = 0;
    if (irq_o) n_pulse++;
    chk(irq_o == m_irq, "R6 irq", int'(irq_o), int'(m_irq));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    cyc(0, 1, a, d);
  endtask

  task automatic rd(input bit [1:0] a, input string tag, input int exp);
    rd_addr_i = a; #1;
    chk(rd_data_o == exp[7:0], tag, int'(rd_data_o), exp);
  endtask

  task automatic rd_all(input string tag);
    rd(0, tag, int'((m_base >> 8) & 255));
    rd(1, tag, int'(m_cnt));
    rd(2, tag, int'(m_mod));
    rd(3, tag, int'(m_ctl));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd5150;
    void'($urandom(seed));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(irq_o == 1'b0, "R9 irq after reset", int'(irq_o), 0);
    rd_all("R9 reset");

    // R1 divider rate and hold
    ticks(63);
    rd(0, "R1 div before 64 ticks", 0);
    ticks(1);
    rd(0, "R1 div after 64 ticks", 1);
    repeat (10) cyc(0, 0, 0, 0);
    rd(0, "R1 div holds without tick", 1);

    // R2 divider clear restarts phase
    ticks(100);
    wr(0, 8'h5A);
    rd_all("R2 div clear");
    wr(3, 8'h05);
    ticks(3);
    rd(1, "R2 phase restart before", 0);
    ticks(1);
    rd(1, "R2 phase restart step", 1);

    // R3 each threshold
    for (int s = 0; s < 4; s++) begin
      wr(3, 8'(s));
      wr(1, 8'h00);
      wr(0, 8'h00);
      wr(3, 8'(4 | s));
      ticks(int'(thr_of(s) / 4) - 1);
      rd(1, "R3 one tick before threshold", 0);
      ticks(1);
      rd(1, "R3 at threshold", 1);
    end

    // R5/R6 overflow reload and single pulse
    n_ovf = 0; n_pulse = 0;
    wr(3, 8'h01); wr(2, 8'd200); wr(1, 8'd254); wr(0, 0); wr(3, 8'h05);
    ticks(8);
    rd(1, "R5 reload from modulo", 200);
    chk(n_pulse == 1, "R6 pulses per overflow", n_pulse, 1);

    // R7 counter write beats a step at 255
    wr(1, 8'd255); wr(0, 0);
    ticks(3);
    cyc(1, 1, 2'd1, 8'd9);
    rd(1, "R7 write wins", 9);

    // R4 disabled holds, no irq
    n_pulse = 0;
    wr(3, 8'h01); wr(1, 8'd255);
    ticks(2000);
    rd(1, "R4 disabled hold", 255);
    chk(n_pulse == 0, "R4 no irq while disabled", n_pulse, 0);

    // R8 control upper bits and map
    wr(3, 8'hFF);
    rd(3, "R8 control width", 7);
    wr(2, 8'hC3);
    rd_all("R8 map");

    // random mix
    n_ovf = 0; n_pulse = 0;
    for (int i = 0; i < 30000; i++) begin
      bit tk, we;
      bit [1:0] a;
      bit [7:0] d;
      tk = ($urandom % 4) != 0;
      we = ($urandom % 12) == 0;
      a  = 2'($urandom);
      d  = 8'($urandom);
      if (we && a == 2'd0 && ($urandom % 4) != 0) a = 2'd2;
      if (we && a == 2'd1) d = 8'd240 + 8'($urandom % 16);
      if (we && a == 2'd3) d = d | 8'h04;
      cyc(tk, we, a, d);
      if (i % 32 == 0) rd_all("R8 random regs");
    end
    chk(n_pulse == n_ovf, "R6 random pulse total", n_pulse, n_ovf);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule